// File: doc/BRIEF.md
# Isolated Digital I/O Register Block

This block is the byte-wide register file of a digital I/O card with sixteen output lines and sixteen input lines. A simple bus gives it an address, a read strobe, a write strobe and write data. Read data comes back combinationally in the same cycle as the strobe. Two latches hold the output levels, and software can read them back to change single bits. The input lines pass through a synchronizer and an optional glitch filter before software sees them.

Some addresses act as commands. Reading the interrupt-control address arms interrupts and writing it disarms them. Reading the filter-control address switches the filters on and writing it switches them off. Any write to the low input address acknowledges a pending interrupt. A change in either direction on any accepted input raises a pending flag and a per-byte change bit, but only while interrupts are armed. The interrupt line is a level output that stays high until software clears the pending flag or disarms interrupts.

Top module: `iso_dio_regs`

## Requirements
- R1: After reset the output pins are all 0, irq is low, interrupts are disarmed, filters are off, and reads of offsets 0, 4 and 6 return 0x00.
- R2: A write to offset 0 sets output pins 7..0 and a write to offset 4 sets output pins 15..8. Reading either offset returns the value last written there.
- R3: A read of offset 1 returns the accepted levels of inputs 7..0, and a read of offset 5 returns inputs 15..8 (bit n of the byte is line n of that group).
- R4: A read of offset 2 arms interrupts. Any write to offset 2 disarms them, whatever the data. A read of offset 2 returns 0x00.
- R5: A read of offset 3 turns the filters on. Any write to offset 3 turns them off, and a read of offset 3 returns 0x00. With filters on, an input level must differ from the accepted level for 4 consecutive sample ticks before it is taken. A 2-cycle pulse is then dropped, while with filters off the same pulse is seen.
- R6: While interrupts are armed, a rising or a falling change on an accepted input sets the pending flag. The status byte at offset 6 then has bit 2 = pending, bit 0 = change on inputs 7..0, bit 1 = change on inputs 8..15 and all other bits 0.
- R7: Any write to offset 1 clears the whole status byte. Writes to offsets 5 and 6 change nothing.
- R8: irq is high exactly while the pending flag is set and interrupts are armed. Input changes while interrupts are disarmed do not set the pending flag. Disarming keeps an existing pending flag.
- R9: Reads of offsets 7 and above return 0x00 and have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| din | input | 16 | Input lines from the isolation stage |
| dout | output | 16 | Output latch levels to the line drivers |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong arm or filter flag inside the block does not show up when software reads it back. It shows up a few cycles after the next input change, as an irq level or a status byte that differs from the one software expects. The bench therefore follows every command access with an input change, then reads the status byte and samples irq. A stuck change bit or a missed acknowledge shows up in the first status read after the clear. A lost output latch shows up at once on dout and in the readback of offset 0 or 4.

// File: rtl/iso_dio_pkg.sv
package iso_dio_pkg;
    localparam int DW = 8;
    localparam int AW = 4;

    localparam logic [AW-1:0] OFS_DRV_LO  = 4'd0;
    localparam logic [AW-1:0] OFS_SNS_LO  = 4'd1;
    localparam logic [AW-1:0] OFS_IRQ_CMD = 4'd2;
    localparam logic [AW-1:0] OFS_FLT_CMD = 4'd3;
    localparam logic [AW-1:0] OFS_DRV_HI  = 4'd4;
    localparam logic [AW-1:0] OFS_SNS_HI  = 4'd5;
    localparam logic [AW-1:0] OFS_STATUS  = 4'd6;

    typedef struct packed {
        logic pend;
        logic hi;
        logic lo;
    } irq_stat_t;

    typedef struct packed {
        logic arm;
        logic disarm;
        logic flt_on;
        logic flt_off;
        logic ack;
        logic wr_lo;
        logic wr_hi;
    } bus_cmd_t;

    function automatic logic [DW-1:0] stat_to_byte(irq_stat_t s);
        return {{(DW-3){1'b0}}, s.pend, s.hi, s.lo};
    endfunction
endpackage

// File: rtl/dio_in_cond.sv
module dio_in_cond #(
    parameter int NCH         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int TICK_DIV    = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           flt_on,
    input  logic [NCH-1:0] pins,
    output logic [NCH-1:0] acc
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [NCH-1:0] sync_q [SYNC_STAGES];
    logic           tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
        end else begin
            sync_q[0] <= pins;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    generate
        if (TICK_DIV > 1) begin : g_div
            localparam int TW = $clog2(TICK_DIV);
            logic [TW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || div_q == TW'(TICK_DIV - 1)) div_q <= '0;
                else                                   div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == TW'(TICK_DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic [CW-1:0] cnt_q;
            logic          s;
            assign s = sync_q[SYNC_STAGES-1][c];
            always_ff @(posedge clk) begin
                if (rst) begin
                    acc[c] <= 1'b0;
                    cnt_q  <= '0;
                end else if (!flt_on) begin
                    acc[c] <= s;
                    cnt_q  <= '0;
                end else if (s == acc[c]) begin
                    cnt_q  <= '0;
                end else if (tick) begin
                    if (cnt_q == CW'(FILT_LEN - 1)) begin
                        acc[c] <= s;
                        cnt_q  <= '0;
                    end else begin
                        cnt_q  <= cnt_q + 1'b1;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dio_chg_irq.sv
module dio_chg_irq
    import iso_dio_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] acc,
    input  logic           armed,
    input  logic           ack,
    output irq_stat_t      stat,
    output logic           evt
);
    localparam int HALF = NCH / 2;

    logic [NCH-1:0] prev_q;
    logic [NCH-1:0] diff;
    logic           chg_lo, chg_hi;
    irq_stat_t      stat_d;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= acc;
    end

    assign diff   = acc ^ prev_q;
    assign chg_lo = |diff[HALF-1:0];
    assign chg_hi = |diff[NCH-1:HALF];
    assign evt    = armed && (chg_lo || chg_hi);

    always_comb begin
        stat_d = ack ? '0 : stat;
        if (armed && chg_lo) stat_d.lo = 1'b1;
        if (armed && chg_hi) stat_d.hi = 1'b1;
        if (evt)             stat_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= stat_d;
    end
endmodule

// File: rtl/iso_dio_regs.sv
module iso_dio_regs
    import iso_dio_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int TICK_DIV    = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [2*DW-1:0] din,
    output logic [2*DW-1:0] dout,
    output logic            irq
);
    localparam int NCH = 2 * DW;

    logic [DW-1:0]  drv_lo_q, drv_hi_q;
    logic           irq_en_q, flt_on_q;
    logic [NCH-1:0] acc;
    irq_stat_t      stat_q;
    logic           evt;
    bus_cmd_t       cmd;

    always_comb begin
        cmd = '0;
        if (bus_wr) begin
            case (bus_addr)
                OFS_DRV_LO:  cmd.wr_lo   = 1'b1;
                OFS_SNS_LO:  cmd.ack     = 1'b1;
                OFS_IRQ_CMD: cmd.disarm  = 1'b1;
                OFS_FLT_CMD: cmd.flt_off = 1'b1;
                OFS_DRV_HI:  cmd.wr_hi   = 1'b1;
                default: ;
            endcase
        end else if (bus_rd) begin
            case (bus_addr)
                OFS_IRQ_CMD: cmd.arm    = 1'b1;
                OFS_FLT_CMD: cmd.flt_on = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_lo_q <= '0;
            drv_hi_q <= '0;
            irq_en_q <= 1'b0;
            flt_on_q <= 1'b0;
        end else begin
            if (cmd.wr_lo)   drv_lo_q <= bus_wdata;
            if (cmd.wr_hi)   drv_hi_q <= bus_wdata;
            if (cmd.arm)     irq_en_q <= 1'b1;
            if (cmd.disarm)  irq_en_q <= 1'b0;
            if (cmd.flt_on)  flt_on_q <= 1'b1;
            if (cmd.flt_off) flt_on_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_DRV_LO: bus_rdata = drv_lo_q;
                OFS_SNS_LO: bus_rdata = acc[DW-1:0];
                OFS_DRV_HI: bus_rdata = drv_hi_q;
                OFS_SNS_HI: bus_rdata = acc[NCH-1:DW];
                OFS_STATUS: bus_rdata = stat_to_byte(stat_q);
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign dout = {drv_hi_q, drv_lo_q};
    assign irq  = stat_q.pend && irq_en_q;

    dio_in_cond #(
        .NCH(NCH), .SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .TICK_DIV(TICK_DIV)
    ) u_cond (
        .clk(clk), .rst(rst), .flt_on(flt_on_q), .pins(din), .acc(acc)
    );

    dio_chg_irq #(.NCH(NCH)) u_chg (
        .clk(clk), .rst(rst), .acc(acc), .armed(irq_en_q), .ack(cmd.ack),
        .stat(stat_q), .evt(evt)
    );
endmodule

// File: rtl/dio_regs_chk.sv
module dio_regs_chk
    import iso_dio_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_rd,
    input logic            bus_wr,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic [2*DW-1:0] dout,
    input logic            irq,
    input logic            irq_en_q,
    input logic            flt_on_q,
    input irq_stat_t       stat_q,
    input logic            evt
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dout == '0 && !irq)); // R1
    AST_LO_LATCH: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_DRV_LO) |=> dout[DW-1:0] == $past(bus_wdata)); // R2
    AST_HI_LATCH: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_DRV_HI) |=> dout[2*DW-1:DW] == $past(bus_wdata)); // R2
    AST_ARM_BY_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == OFS_IRQ_CMD) |=> irq_en_q); // R4
    AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_IRQ_CMD) |=> !irq); // R4
    AST_FILT_BY_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == OFS_FLT_CMD) |=> flt_on_q); // R5
    AST_PEND_HAS_SRC: assert property (@(posedge clk) disable iff (rst)
        stat_q.pend |-> (stat_q.lo || stat_q.hi)); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_SNS_LO && !evt) |=> stat_q == '0); // R7
    AST_NO_ARM_NO_PEND: assert property (@(posedge clk) disable iff (rst)
        (!irq_en_q && !stat_q.pend) |=> !stat_q.pend); // R8
    AST_HIGH_OFS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr > OFS_STATUS) |-> bus_rdata == '0); // R9
endmodule

bind iso_dio_regs dio_regs_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dout(dout), .irq(irq),
    .irq_en_q(irq_en_q), .flt_on_q(flt_on_q), .stat_q(stat_q), .evt(evt)
);

// File: tb/sim_iso_dio_regs.sv
module sim_iso_dio_regs;
    localparam int CYC = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CYC/2) clk = ~clk;

    iso_dio_regs u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din(din), .dout(dout), .irq(irq)
    );

    // monitor: pops expected read data in the middle of the low phase
    always @(negedge clk) begin
        #(CYC/4);
        if (bus_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: actual %02h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: read data actual %02h expected %02h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_chk(input logic [15:0] e_dout, input logic e_irq, input string t);
        #(CYC/4);
        checks++;
        if (dout !== e_dout || irq !== e_irq) begin
            errors++;
            $display("FAIL %s: dout/irq actual %04h/%0b expected %04h/%0b",
                     t, dout, irq, e_dout, e_irq);
        end
    endtask

    initial begin
        #(CYC * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(5);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        pin_chk(16'h0000, 1'b0, "R1");
        rd(4'd0, 8'h00, "R1");
        rd(4'd4, 8'h00, "R1");
        rd(4'd6, 8'h00, "R1");
        // R2 output latches
        wr(4'd0, 8'hA5);
        wr(4'd4, 8'h3C);
        pin_chk(16'h3CA5, 1'b0, "R2");
        rd(4'd0, 8'hA5, "R2");
        rd(4'd4, 8'h3C, "R2");
        // R3 inputs while disarmed; R8 no pending from disarmed edges
        din = 16'h8001;
        idle(8);
        rd(4'd1, 8'h01, "R3");
        rd(4'd5, 8'h80, "R3");
        rd(4'd6, 8'h00, "R8");
        // R4 arm by read, then a rising edge on the low group (R6)
        rd(4'd2, 8'h00, "R4");
        din = 16'h8009;
        idle(8);
        pin_chk(16'h3CA5, 1'b1, "R6");
        rd(4'd6, 8'h05, "R6");
        // R7 writes to 5 and 6 ignored, write to 1 clears
        wr(4'd5, 8'hFF);
        wr(4'd6, 8'hFF);
        rd(4'd6, 8'h05, "R7");
        rd(4'd5, 8'h80, "R7");
        wr(4'd1, 8'h00);
        idle(1);
        pin_chk(16'h3CA5, 1'b0, "R7");
        rd(4'd6, 8'h00, "R7");
        // R6 falling edge on the high group
        din = 16'h0009;
        idle(8);
        pin_chk(16'h3CA5, 1'b1, "R6");
        rd(4'd6, 8'h06, "R6");
        wr(4'd1, 8'h5A);
        // R4/R8 disarm keeps pending, hides irq; re-arm shows it
        din = 16'h0008;
        idle(8);
        wr(4'd2, 8'hFF);
        pin_chk(16'h3CA5, 1'b0, "R8");
        rd(4'd6, 8'h05, "R8");
        rd(4'd2, 8'h00, "R4");
        pin_chk(16'h3CA5, 1'b1, "R8");
        wr(4'd1, 8'h00);
        // R4 disarmed edges do not pend
        wr(4'd2, 8'h00);
        din = 16'h0003;
        idle(8);
        pin_chk(16'h3CA5, 1'b0, "R4");
        rd(4'd6, 8'h00, "R8");
        // R5 filter on: 2-cycle pulse dropped, long level taken
        rd(4'd2, 8'h00, "R4");
        rd(4'd3, 8'h00, "R5");
        @(negedge clk); din = 16'h0013;
        idle(2);        din = 16'h0003;
        idle(8);
        rd(4'd1, 8'h03, "R5");
        rd(4'd6, 8'h00, "R5");
        din = 16'h0013;
        idle(10);
        rd(4'd1, 8'h13, "R5");
        rd(4'd6, 8'h05, "R5");
        wr(4'd1, 8'h00);
        // R5 filter off: the same short pulse is seen
        wr(4'd3, 8'h00);
        @(negedge clk); din = 16'h0033;
        idle(2);        din = 16'h0013;
        idle(8);
        rd(4'd6, 8'h05, "R5");
        wr(4'd1, 8'h00);
        // R9 high offsets read zero, no arming side effect
        wr(4'd2, 8'h00);
        rd(4'd7, 8'h00, "R9");
        rd(4'd9, 8'h00, "R9");
        rd(4'd15, 8'h00, "R9");
        din = 16'h1013;
        idle(8);
        rd(4'd6, 8'h00, "R9");
        pin_chk(16'h3CA5, 1'b0, "R9");
        rd(4'd0, 8'hA5, "R2");
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule